// File: doc/BRIEF.md
# Uncorrectable Error Mask and Reporting Gate

This block takes per-cycle detection pulses for uncorrectable link and transaction-layer errors, together with the header of the packet that raised them. It records every detected error in a status register. It then decides, per error, whether the error is reported. A 32-bit mask register controls three reporting paths at once: the fatal and non-fatal output pulses, the header log, and the first-error pointer. A severity register uses the same bit layout as the mask and steers each reported error to either the fatal output or the non-fatal output.

The mask is sticky. A power-on reset initialises it, and it keeps its value through an ordinary reset. Both resets are asynchronous and active-low, and each is released synchronously through a two-stage synchroniser. A small register port gives software access. Reads are combinational and writes take effect at the clock edge. The port has four addresses: 0 is status (write 1 to clear), 1 is mask, 2 is severity, and 3 is the first-error pointer (read-only, in bits 4:0).

Top module: `uncor_err_report`

## Requirements
- R1: The implemented bits are 0, 4, 5, 12 to 20 and 22 (set 0x005F_F031) in the mask, severity and status registers. Every other bit reads as 0, and writes to it have no effect.
- R2: After a power-on reset, the mask reads 0x0040_0000, the severity register reads 0x0006_2031, the status reads 0, the pointer reads 0, and all outputs are low.
- R3: An ordinary reset (rst_n low with por_n high) leaves the mask unchanged. It returns status, severity, pointer, log valid and the outputs to their reset values.
- R4: Mask bit 5 takes written data only while sd_cap_en is 1. Otherwise it keeps its value.
- R5: An unmasked detection raises fatal_o for one cycle if its severity bit is 1, or nonfatal_o if its severity bit is 0. The pulse comes in the cycle after detection, and one pulse covers all errors of a cycle.
- R6: A detection whose mask bit is set raises neither fatal_o nor nonfatal_o.
- R7: A detection sets its status bit whether or not it is masked. Writing 1 to a status bit clears it. A detection in the same cycle as the clear wins.
- R8: When no capture is held, the first unmasked detection loads its bit number into the pointer and its header into the log. hdr_log_vld_o rises in the next cycle.
- R9: A masked detection changes neither the pointer nor the header log, and it does not set hdr_log_vld_o.
- R10: Once a capture is held, the pointer and the log stay frozen until software writes 1 to the status bit that the pointer names. That write drops hdr_log_vld_o and re-arms capture. An error detected in the same cycle as that write is not captured.
- R11: When several unmasked errors are detected in one cycle, the lowest-numbered one is captured.
- R12: Detection pulses on unimplemented bit positions are ignored. They set no status, cause no output pulse and cause no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async active-low; initialises everything including the mask |
| rst_n | input | 1 | Ordinary reset, async active-low; spares the mask |
| sd_cap_en | input | 1 | Capability strap making mask bit 5 writable |
| err_det | input | 32 | One-cycle detection pulses, one per error bit |
| err_hdr | input | HDR_W | Header of the packet carrying the detected error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 mask, 2 severity, 3 pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| fatal_o | output | 1 | One-cycle fatal error pulse |
| nonfatal_o | output | 1 | One-cycle non-fatal error pulse |
| hdr_log_o | output | HDR_W | Captured header |
| hdr_log_vld_o | output | 1 | A capture is held |
| first_ptr_o | output | 5 | Bit number of the captured first error |

## Verification
A corrupt mask or severity bit shows up one cycle after the matching detection: a pulse appears on the wrong output, or a pulse is missing. A wrong capture-arm flag shows the same way. The pointer or log moves when it should stay frozen, or stays frozen after a re-arm, and this is visible on the next detection. Loss of stickiness is visible on a register read as soon as an ordinary reset is released. A wrong status update is visible on the next read of address 0.

// File: rtl/uer_pkg.sv
package uer_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned PTR_W = $clog2(REG_W);
  localparam logic [REG_W-1:0] IMPL_BITS = 32'h005F_F031;
  localparam logic [REG_W-1:0] MASK_POR  = 32'h0040_0000;
  localparam logic [REG_W-1:0] SEV_RST   = 32'h0006_2031;
  localparam int unsigned SD_BIT = 5;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_SEV  = 2'd2,
    A_PTR  = 2'd3
  } uer_addr_e;
endpackage

// File: rtl/uer_rst_sync.sv
module uer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb sh_nxt = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_nxt;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/uer_csr.sv
module uer_csr
  import uer_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL     = IMPL_BITS,
  parameter logic [REG_W-1:0] MASK_INI = MASK_POR,
  parameter logic [REG_W-1:0] SEV_INI  = SEV_RST
) (
  input  logic             clk,
  input  logic             por_rst_n,
  input  logic             sys_rst_n,
  input  logic             sd_cap_en,
  input  logic [REG_W-1:0] det_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] sev_o,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] stat_clr_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [REG_W-1:0] SD_ONE = REG_W'(1) << SD_BIT;

  logic [REG_W-1:0] mask_q, mask_nxt, sev_q, sev_nxt, stat_q, stat_nxt;
  logic [REG_W-1:0] mask_wmask, clr_vec;
  logic             mask_en, sev_en, stat_en;

  always_comb begin
    mask_wmask = sd_cap_en ? IMPL : (IMPL & ~SD_ONE);
    mask_en    = wr_i && (addr_i == A_MASK);
    sev_en     = wr_i && (addr_i == A_SEV);
    clr_vec    = (wr_i && (addr_i == A_STAT)) ? (wdata_i & IMPL) : '0;
    stat_en    = (|clr_vec) || (|det_i);
    mask_nxt   = (mask_q & ~mask_wmask) | (wdata_i & mask_wmask);
    sev_nxt    = wdata_i & IMPL;
    stat_nxt   = ((stat_q & ~clr_vec) | det_i) & IMPL;
  end

  // sticky mask: power-on reset only
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)   mask_q <= MASK_INI;
    else if (mask_en) mask_q <= mask_nxt;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      sev_q  <= SEV_INI;
      stat_q <= '0;
    end else begin
      if (sev_en)  sev_q  <= sev_nxt;
      if (stat_en) stat_q <= stat_nxt;
    end
  end

  always_comb begin
    unique case (uer_addr_e'(addr_i))
      A_STAT:  rdata_o = stat_q;
      A_MASK:  rdata_o = mask_q;
      A_SEV:   rdata_o = sev_q;
      default: rdata_o = {{(REG_W-PTR_W){1'b0}}, ptr_i};
    endcase
  end

  assign mask_o     = mask_q;
  assign sev_o      = sev_q;
  assign stat_o     = stat_q;
  assign stat_clr_o = clr_vec;

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ((mask_q | sev_q | stat_q) & ~IMPL) == '0);

  // R7
  status_set_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (|det_i) |=> ((stat_q & $past(det_i)) == $past(det_i)));

  // R4
  sd_locked_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!sd_cap_en) |=> (mask_q[SD_BIT] == $past(mask_q[SD_BIT])));
endmodule

// File: rtl/uer_first_err.sv
module uer_first_err
  import uer_pkg::*;
#(
  parameter int unsigned HDR_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rpt_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [REG_W-1:0] stat_clr_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [HDR_W-1:0] hdr_o,
  output logic             vld_o
);
  logic [PTR_W-1:0] ptr_q, ptr_nxt, low_idx;
  logic [HDR_W-1:0] hdr_q;
  logic             vld_q, vld_nxt, cap, rearm, vld_en;

  always_comb begin
    low_idx = '0;
    for (int i = REG_W-1; i >= 0; i--) begin
      if (rpt_i[i]) low_idx = PTR_W'(i);
    end
  end

  always_comb begin
    cap     = (|rpt_i) && !vld_q;
    rearm   = vld_q && stat_clr_i[ptr_q];
    vld_en  = cap || rearm;
    vld_nxt = cap;
    ptr_nxt = low_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ptr_q <= '0;
      hdr_q <= '0;
    end else begin
      if (vld_en) vld_q <= vld_nxt;
      if (cap) begin
        ptr_q <= ptr_nxt;
        hdr_q <= hdr_i;
      end
    end
  end

  assign ptr_o = ptr_q;
  assign hdr_o = hdr_q;
  assign vld_o = vld_q;

  // R10
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !stat_clr_i[ptr_q]) |=> (vld_q && $stable(ptr_q) && $stable(hdr_q)));

  // R8
  capture_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(|rpt_i));

  // R11
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> (($past(rpt_i) & ((REG_W'(1) << ptr_q) - REG_W'(1))) == '0));
endmodule

// File: rtl/uncor_err_report.sv
module uncor_err_report
  import uer_pkg::*;
#(
  parameter int unsigned HDR_W   = 128,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             sd_cap_en,
  input  logic [31:0]      err_det,
  input  logic [HDR_W-1:0] err_hdr,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             fatal_o,
  output logic             nonfatal_o,
  output logic [HDR_W-1:0] hdr_log_o,
  output logic             hdr_log_vld_o,
  output logic [4:0]       first_ptr_o
);
  logic             por_rst_n, sys_rst_n, sys_arst_n;
  logic [REG_W-1:0] det_v, rpt_v, mask_v, sev_v, stat_v, clr_v;
  logic [PTR_W-1:0] ptr_v;
  logic             fatal_q, fatal_nxt, nonf_q, nonf_nxt;

  assign sys_arst_n = por_n & rst_n;

  uer_rst_sync #(.STAGES(SYNC_ST)) u_por_sync (
    .clk(clk), .arst_n(por_n), .rst_n_o(por_rst_n));
  uer_rst_sync #(.STAGES(SYNC_ST)) u_sys_sync (
    .clk(clk), .arst_n(sys_arst_n), .rst_n_o(sys_rst_n));

  always_comb begin
    det_v     = err_det & IMPL_BITS;
    rpt_v     = det_v & ~mask_v;
    fatal_nxt = |(rpt_v & sev_v);
    nonf_nxt  = |(rpt_v & ~sev_v);
  end

  uer_csr u_csr (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .sd_cap_en(sd_cap_en), .det_i(det_v), .wr_i(reg_wr),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .ptr_i(ptr_v),
    .mask_o(mask_v), .sev_o(sev_v), .stat_o(stat_v),
    .stat_clr_o(clr_v), .rdata_o(reg_rdata));

  uer_first_err #(.HDR_W(HDR_W)) u_first (
    .clk(clk), .rst_n(sys_rst_n), .rpt_i(rpt_v), .hdr_i(err_hdr),
    .stat_clr_i(clr_v), .ptr_o(ptr_v), .hdr_o(hdr_log_o),
    .vld_o(hdr_log_vld_o));

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      fatal_q <= 1'b0;
      nonf_q  <= 1'b0;
    end else begin
      fatal_q <= fatal_nxt;
      nonf_q  <= nonf_nxt;
    end
  end

  assign fatal_o     = fatal_q;
  assign nonfatal_o  = nonf_q;
  assign first_ptr_o = ptr_v;

  // R6
  masked_silent_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ((err_det & IMPL_BITS & ~mask_v) == '0) |=> (!fatal_o && !nonfatal_o));

  // R12
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ((err_det & IMPL_BITS) == '0) |=> (!fatal_o && !nonfatal_o));

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (fatal_o || nonfatal_o) |-> $past(|(err_det & IMPL_BITS)));
endmodule

// File: tb/uncor_err_report_test.sv
module uncor_err_report_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HW = 128;
  localparam logic [31:0] IMPL = 32'h005F_F031;

  logic          clk = 1'b0;
  logic          por_n, rst_n, sd_cap_en, reg_wr;
  logic [31:0]   err_det, reg_wdata, reg_rdata;
  logic [HW-1:0] err_hdr, hdr_log_o;
  logic [1:0]    reg_addr;
  logic          fatal_o, nonfatal_o, hdr_log_vld_o;
  logic [4:0]    first_ptr_o;

  int checks = 0;
  int fails  = 0;

  uncor_err_report #(.HDR_W(HW)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sd_cap_en(sd_cap_en),
    .err_det(err_det), .err_hdr(err_hdr), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fatal_o(fatal_o), .nonfatal_o(nonfatal_o), .hdr_log_o(hdr_log_o),
    .hdr_log_vld_o(hdr_log_vld_o), .first_ptr_o(first_ptr_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [HW-1:0] act,
                       input logic [HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // pulse for one edge; on return outputs reflect the pulse
  task automatic pulse(input logic [31:0] e, input logic [HW-1:0] h);
    @(negedge clk);
    err_det = e; err_hdr = h;
    @(negedge clk);
    err_det = '0;
  endtask

  task automatic do_reset(input logic por);
    @(negedge clk);
    if (por) por_n = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd1, d); check("R2 mask", d, 32'h0040_0000);
    rd(2'd2, d); check("R2 sev", d, 32'h0006_2031);
    rd(2'd0, d); check("R2 status", d, 0);
    rd(2'd3, d); check("R2 ptr", d, 0);
    check("R2 outputs", {fatal_o, nonfatal_o, hdr_log_vld_o}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    sd_cap_en = 1'b0;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d);
    check("R1/R4 mask write no cap", d, 32'h005F_F011);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d);
    check("R1 sev reserved", d, IMPL);
    wr(2'd2, 32'h0006_2031);
    sd_cap_en = 1'b1;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d);
    check("R4 sd bit writable", d, IMPL);
    sd_cap_en = 1'b0;
    wr(2'd1, 32'h0); rd(2'd1, d);
    check("R4 sd bit held", d, 32'h0000_0020);
    sd_cap_en = 1'b1;
    wr(2'd1, 32'h0); rd(2'd1, d);
    check("R1 mask cleared", d, 0);
    sd_cap_en = 1'b0;
  endtask

  task automatic t_report;
    logic [31:0] d;
    pulse(32'h0000_1000, 128'hA);
    check("R5 nonfatal pulse", {fatal_o, nonfatal_o}, 2'b01);
    check("R8 capture", {hdr_log_vld_o, 3'b0, first_ptr_o, hdr_log_o[7:0]}, {1'b1, 3'b0, 5'd12, 8'hA});
    @(negedge clk);
    check("R5 single pulse", {fatal_o, nonfatal_o}, 2'b00);
    pulse(32'h0000_0010, 128'hB);
    check("R5 fatal pulse", {fatal_o, nonfatal_o}, 2'b10);
    check("R10 frozen", {first_ptr_o, hdr_log_o[7:0]}, {5'd12, 8'hA});
    rd(2'd0, d); check("R7 status bits", d, 32'h0000_1010);
    wr(2'd0, 32'h0000_0010);
    check("R10 other clear keeps", hdr_log_vld_o, 1'b1);
    wr(2'd0, 32'h0000_1000);
    check("R10 rearm", hdr_log_vld_o, 1'b0);
    rd(2'd0, d); check("R7 w1c", d, 0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    wr(2'd1, 32'h0000_4000);
    pulse(32'h0000_4000, 128'hC);
    check("R6 masked silent", {fatal_o, nonfatal_o}, 2'b00);
    check("R9 no capture", {hdr_log_vld_o, first_ptr_o}, {1'b0, 5'd12});
    rd(2'd0, d); check("R7 masked status", d, 32'h0000_4000);
    pulse(32'h0001_4000, 128'hD);
    check("R11 skips masked", {hdr_log_vld_o, first_ptr_o, hdr_log_o[7:0]}, {1'b1, 5'd16, 8'hD});
    check("R5 unmasked pulse", {fatal_o, nonfatal_o}, 2'b01);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    pulse(32'h0048_2000, 128'hE);
    check("R11 lowest wins", {first_ptr_o, hdr_log_o[7:0]}, {5'd13, 8'hE});
    check("R5 both severities", {fatal_o, nonfatal_o}, 2'b11);
    // clear and detect in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF;
    err_det = 32'h0010_0000;
    @(negedge clk);
    reg_wr = 1'b0; err_det = '0;
    check("R10 same-cycle no capture", hdr_log_vld_o, 1'b0);
    rd(2'd0, d); check("R7 set wins", d, 32'h0010_0000);
    wr(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    pulse(32'hFFA0_0FCE, 128'hF);
    check("R12 no pulse", {fatal_o, nonfatal_o}, 2'b00);
    check("R12 no capture", hdr_log_vld_o, 1'b0);
    rd(2'd0, d); check("R12 no status", d, 0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    wr(2'd1, 32'h0000_1001);
    wr(2'd2, 32'h0);
    pulse(32'h0000_0010, 128'h5);
    do_reset(1'b0);
    rd(2'd1, d); check("R3 mask kept", d, 32'h0000_1001);
    rd(2'd2, d); check("R3 sev reset", d, 32'h0006_2031);
    rd(2'd0, d); check("R3 status reset", d, 0);
    check("R3 log reset", {hdr_log_vld_o, first_ptr_o}, 0);
    do_reset(1'b1);
    rd(2'd1, d); check("R2 mask after por", d, 32'h0040_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog: actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; sd_cap_en = 1'b0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0; err_det = '0; err_hdr = '0;
    do_reset(1'b1);
    t_reset();
    t_regs();
    t_report();
    t_masked();
    t_simul();
    t_reserved();
    t_sticky();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule